// File: doc/BRIEF.md
# Supply Warning Status and Threshold Select Register

This block is an eight-bit control and status register that sits beside a supply-voltage supervisor. It watches a digital warning-detect signal coming from an analog comparator, passes it through a two-flop synchronizer, and latches a sticky warning flag that software can read. Software clears the flag by writing one to an acknowledge bit. The clear takes effect only when the warning condition has gone away.

The register also stores two threshold-select bits. One picks the trip point of the supply-detect comparator and the other picks the trip point of the warning comparator. Each select bit drives a high/low trip-select output. A build-time option removes the low trip point, and both outputs then stay on the high trip point.

The register has two reset inputs. Power-on reset clears the stored state. The warm reset input covers every other reset source, and it leaves the flag and both select bits unchanged.

Top module: `lvw_status_reg`

## Requirements
- R1: While `por_n` is sampled low at a clock edge, bits 7..4 of `rd_data` become 0 and both trip-select outputs become 0 (low trip point), in the dual-trip build.
- R2: Bit 7 of `rd_data` is the warning flag. It becomes 1 at the edge where the synchronized `warn_det_i` is high and `det_en_i` is high. The flag reads 1 no later than the third rising edge after `warn_det_i` rises with `det_en_i` high. It never sets while `det_en_i` is low.
- R3: Once set, the warning flag stays 1 after `warn_det_i` falls, until it is acknowledged or power-on reset occurs.
- R4: A write with bit 6 set clears the flag at that edge only if no warning is present. A warning is present when the synchronized detect input is high and `det_en_i` is high. If a set and an acknowledge arrive together, the flag stays 1.
- R5: A write stores `wr_data[5]` as the detect trip select and `wr_data[4]` as the warning trip select. Both read back at the same positions, and 1 means high trip point.
- R6: Bit 6 (acknowledge) and bits 3..0 always read 0. The written value of bit 7 has no effect on the flag.
- R7: While `warm_rst_n` is low and `por_n` is high, the flag and both select bits keep their values, and writes are ignored.
- R8: With parameter `DUAL_TRIP` = 0, both trip-select outputs are 1 whatever the select bits hold.
- R9: With `DUAL_TRIP` = 1, `det_trip_hi_o` equals bit 5 and `warn_trip_hi_o` equals bit 4 of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| warm_rst_n | input | 1 | Any other reset, synchronous, active low; state retained |
| wr_en | input | 1 | Write strobe for this register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| warn_det_i | input | 1 | Asynchronous warning comparator output |
| det_en_i | input | 1 | Supply detection enable |
| det_trip_hi_o | output | 1 | Detect comparator trip select, 1 = high |
| warn_trip_hi_o | output | 1 | Warning comparator trip select, 1 = high |

## Verification
The hardest case to reach is an acknowledge that arrives while the synchronized warning is still high. The flag must then survive. The stimulus holds the detect input high long enough to fill the synchronizer, writes the acknowledge, and checks the flag. It then lowers the input, waits for the synchronizer to drain, and acknowledges again to see the clear. Retention under warm reset is checked the same way: the flag is set, the warm reset is asserted together with a conflicting write, and the register contents must come through unchanged.

// File: rtl/lvw_pkg.sv
// Shared widths and bit positions of the supply warning status register.
// Assumes an eight-bit register bus; the field positions are fixed by software.
package lvw_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned FLAG_BIT   = 7;
    localparam int unsigned ACK_BIT    = 6;
    localparam int unsigned DET_SEL_BIT  = 5;
    localparam int unsigned WARN_SEL_BIT = 4;
    localparam int unsigned RSVD_W     = 4;

    typedef struct packed {
        logic flag;
        logic det_hi;
        logic warn_hi;
    } lvw_state_t;
endpackage

// File: rtl/lvw_sync.sv
// Multi-flop synchronizer for an asynchronous level.
// Assumes the input is a slow level; clears on the combined reset.
module lvw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvw_flag_ctrl.sv
// Sticky warning flag with a conditional write-one acknowledge.
// Assumes warn_i is already synchronized. Set has priority over clear.
// Power-on reset clears the flag; warm reset freezes it.
module lvw_flag_ctrl (
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst_n,
    input  logic warn_i,
    input  logic en_i,
    input  logic ack_i,
    output logic flag_o
);
    logic present;
    assign present = warn_i & en_i;

    // Update the flag: POR clear, warm hold, set first, then acknowledged clear.
    always_ff @(posedge clk) begin
        if (!por_n)              flag_o <= 1'b0;
        else if (!warm_rst_n)    flag_o <= flag_o;
        else if (present)        flag_o <= 1'b1;
        else if (ack_i)          flag_o <= 1'b0;
    end
endmodule

// File: rtl/lvw_sel_reg.sv
// Holds the two trip-point select bits and maps them to the comparator selects.
// With DUAL_TRIP = 0 the outputs are tied to the high trip point.
module lvw_sel_reg #(
    parameter bit DUAL_TRIP = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst_n,
    input  logic wr_i,
    input  logic det_d_i,
    input  logic warn_d_i,
    output logic det_q_o,
    output logic warn_q_o,
    output logic det_hi_o,
    output logic warn_hi_o
);
    // Store the select bits; POR clears them, warm reset holds them.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            det_q_o  <= 1'b0;
            warn_q_o <= 1'b0;
        end else if (warm_rst_n && wr_i) begin
            det_q_o  <= det_d_i;
            warn_q_o <= warn_d_i;
        end
    end

    generate
        if (DUAL_TRIP) begin : g_dual
            assign det_hi_o  = det_q_o;
            assign warn_hi_o = warn_q_o;
        end else begin : g_single
            assign det_hi_o  = 1'b1;
            assign warn_hi_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/lvw_status_reg.sv
// Top level of the supply warning status register.
// Assumes synchronous active-low resets and a single-cycle write strobe.
// The acknowledge bit is a one-cycle strobe and is never stored.
module lvw_status_reg
    import lvw_pkg::*;
#(
    parameter bit          DUAL_TRIP   = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             warn_det_i,
    input  logic             det_en_i,
    output logic             det_trip_hi_o,
    output logic             warn_trip_hi_o
);
    logic       sync_rst_n;
    logic       warn_sync;
    logic       ack_pulse;
    lvw_state_t st;

    assign sync_rst_n = por_n & warm_rst_n;
    assign ack_pulse  = wr_en & wr_data[ACK_BIT];

    lvw_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (sync_rst_n),
        .d_i   (warn_det_i),
        .q_o   (warn_sync)
    );

    lvw_flag_ctrl flag_i (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .warn_i     (warn_sync),
        .en_i       (det_en_i),
        .ack_i      (ack_pulse),
        .flag_o     (st.flag)
    );

    lvw_sel_reg #(.DUAL_TRIP(DUAL_TRIP)) sel_i (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .wr_i       (wr_en),
        .det_d_i    (wr_data[DET_SEL_BIT]),
        .warn_d_i   (wr_data[WARN_SEL_BIT]),
        .det_q_o    (st.det_hi),
        .warn_q_o   (st.warn_hi),
        .det_hi_o   (det_trip_hi_o),
        .warn_hi_o  (warn_trip_hi_o)
    );

    // Assemble the read word; acknowledge and reserved bits read zero.
    always_comb begin
        rd_data               = '0;
        rd_data[FLAG_BIT]     = st.flag;
        rd_data[DET_SEL_BIT]  = st.det_hi;
        rd_data[WARN_SEL_BIT] = st.warn_hi;
    end
endmodule

// File: rtl/lvw_status_chk.sv
// Property checker for the supply warning status register, bound to the top.
module lvw_status_chk #(
    parameter bit DUAL_TRIP = 1'b1
) (
    input logic       clk,
    input logic       por_n,
    input logic       warm_rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       det_trip_hi_o,
    input logic       warn_trip_hi_o
);
    assert_por_clears_R1: assert property (@(posedge clk)
        !por_n |=> rd_data[7:4] == 4'h0);

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[7] && !(wr_en && wr_data[6] && warm_rst_n) |=> rd_data[7]);

    assert_sel_write_R5: assert property (@(posedge clk) disable iff (!por_n)
        wr_en && warm_rst_n |=> rd_data[5:4] == $past(wr_data[5:4]));

    assert_zero_bits_R6: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[6] == 1'b0 && rd_data[3:0] == 4'h0);

    assert_warm_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
        !warm_rst_n |=> $stable(rd_data[7:4]));

    generate
        if (DUAL_TRIP) begin : g_dual_chk
            assert_trip_follow_R9: assert property (@(posedge clk) disable iff (!por_n)
                det_trip_hi_o == rd_data[5] && warn_trip_hi_o == rd_data[4]);
        end else begin : g_single_chk
            assert_single_high_R8: assert property (@(posedge clk) disable iff (!por_n)
                det_trip_hi_o && warn_trip_hi_o);
        end
    endgenerate
endmodule

bind lvw_status_reg lvw_status_chk #(.DUAL_TRIP(DUAL_TRIP)) chk_i (
    .clk            (clk),
    .por_n          (por_n),
    .warm_rst_n     (warm_rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .det_trip_hi_o  (det_trip_hi_o),
    .warn_trip_hi_o (warn_trip_hi_o)
);

// File: tb/lvw_status_reg_tb_top.sv
// Scoreboard bench: the driver queues expected outputs, the monitor compares them.
module lvw_status_reg_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       warn_det_i = 1'b0;
    logic       det_en_i = 1'b0;
    logic [7:0] rd_data, rd_s;
    logic       det_hi, warn_hi, det_hi_s, warn_hi_s;

    typedef struct {
        logic [7:0] rd;
        logic       dhi;
        logic       whi;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    lvw_status_reg dut_i (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .warn_det_i(warn_det_i),
        .det_en_i(det_en_i), .det_trip_hi_o(det_hi), .warn_trip_hi_o(warn_hi)
    );

    lvw_status_reg #(.DUAL_TRIP(1'b0)) dut_single_i (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_s), .warn_det_i(warn_det_i),
        .det_en_i(det_en_i), .det_trip_hi_o(det_hi_s), .warn_trip_hi_o(warn_hi_s)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Drive one cycle of inputs from a falling edge, through the next rising edge.
    task automatic step(input logic w, input logic [7:0] d, input logic wd,
                        input logic en, input logic warm, input logic por);
        @(negedge clk);
        wr_en = w; wr_data = d; warn_det_i = wd; det_en_i = en;
        warm_rst_n = warm; por_n = por;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, warn_det_i, det_en_i, 1'b1, 1'b1);
    endtask

    task automatic expect_out(input logic [7:0] rd, input string req);
        exp_t e;
        e.rd = rd; e.dhi = rd[5]; e.whi = rd[4]; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare one queued item at each falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (rd_data !== e.rd || det_hi !== e.dhi || warn_hi !== e.whi) begin
                errors++;
                $display("FAIL %s: rd=%h dhi=%b whi=%b expected rd=%h dhi=%b whi=%b",
                         e.req, rd_data, det_hi, warn_hi, e.rd, e.dhi, e.whi);
            end
            checks++;
            if (det_hi_s !== 1'b1 || warn_hi_s !== 1'b1) begin
                errors++;
                $display("FAIL R8: single-trip selects=%b%b expected 11", det_hi_s, warn_hi_s);
            end
        end
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: power-on reset state
        step(1'b1, 8'h30, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out(8'h00, "R1");
        // R5/R9: select writes
        step(1'b1, 8'h30, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_out(8'h30, "R5");
        step(1'b1, 8'h10, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_out(8'h10, "R9");
        // R6: bit 7 and reserved bits written, no effect; ack reads 0
        step(1'b1, 8'hCF, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_out(8'h00, "R6");
        step(1'b1, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_out(8'h20, "R5");
        // R2: warning with detection disabled must not set
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
        idle(5);
        expect_out(8'h20, "R2");
        // R2: enable detection; synchronizer already full
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1);
        idle(3);
        expect_out(8'hA0, "R2");
        // R4: acknowledge while warning present, flag survives
        step(1'b1, 8'h60, 1'b1, 1'b1, 1'b1, 1'b1);
        expect_out(8'hA0, "R4");
        // R3: warning gone, flag sticky
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        idle(4);
        expect_out(8'hA0, "R3");
        // R4: acknowledge with no warning clears
        step(1'b1, 8'h60, 1'b0, 1'b1, 1'b1, 1'b1);
        expect_out(8'h20, "R4");
        // set flag again, then change selects
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1);
        idle(4);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        idle(4);
        step(1'b1, 8'h10, 1'b0, 1'b1, 1'b1, 1'b1);
        expect_out(8'h90, "R3");
        // R7: warm reset with a conflicting write holds everything
        step(1'b1, 8'h60, 1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b1, 8'h60, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_out(8'h90, "R7");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        expect_out(8'h90, "R7");
        // R1: power-on reset clears all
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        expect_out(8'h00, "R1");
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_out(8'h00, "R1");
        idle(2);
        done = 1;
        summary();
        $finish;
    end
endmodule